// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block is the clocked controller behind a shadow memory that keeps a nonvolatile copy of an SRAM without a battery. Two comparator flags arrive from analog sensing: the main supply has dropped under its switch threshold, and the reserve capacitor supply has dropped under its threshold. The controller reacts to a supply collapse by saving the SRAM into the nonvolatile array, if anything was written. When the supply comes back, it restores the SRAM from that array. A software trigger and a wired-AND busy line shared between devices can also request a save.

Each save runs as an erase phase followed by a program phase. Each restore runs as a clear phase followed by a transfer phase. A phase code tells the shadow-array model which step is active, and a one-cycle done pulse marks the end of every save or restore. All phase lengths are parameters counted in clock cycles. While any operation runs, the SRAM port is gated off and the shared busy line is pulled low for the whole save. Reset stands for power-up, so the block starts with a restore.

Top module: `pnv_sequencer`

## Requirements
- R1: During reset and right after it, the block runs a restore. `sram_block` is 1 and `nv_phase` is 5 (clear) for CLEAR_CYC cycles after reset is released, then 6 (transfer) for XFER_CYC cycles. It then returns to 0 (idle) with `nv_done` high for one cycle.
- R2: `sram_wr_ok` and `sram_rd_ok` follow their requests only while `sram_block` is 0. An accepted write marks the SRAM as modified, and blocked requests leave that mark unchanged.
- R3: When `vsup_low` rises while idle and `auto_en` is 1, a power-down save starts only if the SRAM was modified since the last completed save. Otherwise the block stays idle (`nv_phase` 0).
- R4: A power-down save first pulls the busy line low for PULSE_CYC cycles (`nv_phase` 1). If `busy_line_in` still reads high in the last pulse cycle, the pull is released and the block returns to idle without saving. The modified mark is kept.
- R5: While `vsup_low` is 1, a restore request is held. The restore runs once `vsup_low` is 0 and the block is idle. It never drives the save phases.
- R6: A save runs `nv_phase` 2 (erase) for ERASE_CYC cycles, then 3 (program) for PROG_CYC cycles. `busy_pull_low` is 1 throughout. At the end, `nv_done` pulses and the modified mark clears.
- R7: While `vcap_low` is 1, software saves and busy-line saves are refused. Power-down saves are not affected by `vcap_low`.
- R8: With `auto_en` at 0, a supply drop starts no save, but the held restore still runs when the supply returns.
- R9: After every save, and whenever an external device holds the busy line low while the block cannot save, the block waits in phase 4 with `sram_block` 1 until `busy_line_in` reads high.
- R10: A `sw_store` pulse while idle starts a save whether or not the SRAM was modified. An external low on the busy line starts a save only when it was modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-up |
| vsup_low | input | 1 | Main supply below switch threshold |
| vcap_low | input | 1 | Reserve capacitor supply below threshold |
| auto_en | input | 1 | Enables the power-down save |
| sw_store | input | 1 | Software save request, sampled while idle |
| busy_line_in | input | 1 | Sampled level of the shared busy line |
| sram_wr_req | input | 1 | SRAM write request |
| sram_rd_req | input | 1 | SRAM read request |
| busy_pull_low | output | 1 | 1 enables the open-drain pull-down on the busy line |
| sram_block | output | 1 | SRAM port is blocked |
| sram_wr_ok | output | 1 | Write accepted this cycle |
| sram_rd_ok | output | 1 | Read output enable this cycle |
| nv_phase | output | 3 | 0 idle, 1 pulse, 2 erase, 3 program, 4 wait release, 5 clear, 6 transfer |
| nv_done | output | 1 | One-cycle pulse after a save or a restore completes |

## Verification
The bench builds the block with PULSE_CYC 2, ERASE_CYC 3, PROG_CYC 3, CLEAR_CYC 2 and XFER_CYC 2. These short lengths let every phase boundary, the last-pulse-cycle sampling of the busy line, and the done pulse be checked cycle by cycle within a few dozen cycles. They also keep room for several complete save and restore rounds. With these values, a clean supply drop, an aborted pulse, the disabled automatic mode, refused saves under low capacitor voltage, and the wait on an externally held line can all be run back to back.

// File: rtl/pnv_pkg.sv
// Shared state encoding for the power-fail sequencer.
// The numeric values are visible on nv_phase and are part of the interface.
package pnv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PULSE = 3'd1,
        ST_ERASE = 3'd2,
        ST_PROG  = 3'd3,
        ST_WAIT  = 3'd4,
        ST_CLEAR = 3'd5,
        ST_XFER  = 3'd6
    } pnv_state_e;

    function automatic int pnv_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pnv_timer.sv
// Phase down-counter. Loading N-1 gives a phase of N cycles.
// Assumes load_val never exceeds what CW bits hold.
module pnv_timer #(
    parameter int             CW      = 8,
    parameter logic [CW-1:0]  RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          cnt_zero
);
    logic [CW-1:0] cnt_q;

    // Count down to zero and hold there until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= RST_VAL;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_zero = (cnt_q == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cnt_zero && !load) |=> cnt_zero); // R6
endmodule

// File: rtl/pnv_sense.sv
// Supply watcher: flags a falling main supply (when automatic saving is
// enabled) and holds a restore request while the supply is low.
// Assumes vsup_low is already synchronous to clk.
module pnv_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic vsup_low,
    input  logic auto_en,
    input  logic recall_take,
    output logic pd_fall,
    output logic recall_pend
);
    logic vlow_q;

    // Previous supply flag; reset high so a low supply at power-up gives no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) vlow_q <= 1'b1;
        else        vlow_q <= vsup_low;
    end

    assign pd_fall = vsup_low && !vlow_q && auto_en;

    // Restore request: set while supply is low, cleared when the FSM takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)           recall_pend <= 1'b0;
        else if (vsup_low)    recall_pend <= 1'b1;
        else if (recall_take) recall_pend <= 1'b0;
    end

    AST_PEND_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n) vsup_low |=> recall_pend); // R5
endmodule

// File: rtl/pnv_dirty.sv
// Modified-since-save flag for the SRAM contents.
// Assumes wr_accept and store_fin are never high together.
module pnv_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic store_fin,
    output logic dirty
);
    // Set on an accepted write, clear when a save completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         dirty <= 1'b0;
        else if (store_fin) dirty <= 1'b0;
        else if (wr_accept) dirty <= 1'b1;
    end
endmodule

// File: rtl/pnv_sequencer.sv
// Power-fail save/restore sequencer. Chooses among power-down, software
// and busy-line save triggers and the held restore request, times every
// phase, gates the SRAM port and pulls the shared busy line low while saving.
// Assumes all inputs are synchronous to clk; reset represents power-up.
module pnv_sequencer
    import pnv_pkg::*;
#(
    parameter int PULSE_CYC = 10,
    parameter int ERASE_CYC = 1000000,
    parameter int PROG_CYC  = 1000000,
    parameter int CLEAR_CYC = 30000,
    parameter int XFER_CYC  = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsup_low,
    input  logic       vcap_low,
    input  logic       auto_en,
    input  logic       sw_store,
    input  logic       busy_line_in,
    input  logic       sram_wr_req,
    input  logic       sram_rd_req,
    output logic       busy_pull_low,
    output logic       sram_block,
    output logic       sram_wr_ok,
    output logic       sram_rd_ok,
    output logic [2:0] nv_phase,
    output logic       nv_done
);
    localparam int MAXC = pnv_max(pnv_max(pnv_max(PULSE_CYC, ERASE_CYC), pnv_max(PROG_CYC, CLEAR_CYC)), XFER_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] L_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] L_ERASE = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] L_PROG  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] L_CLEAR = CW'(CLEAR_CYC - 1);
    localparam logic [CW-1:0] L_XFER  = CW'(XFER_CYC - 1);

    pnv_state_e    st_q, st_d;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          cnt_zero;
    logic          done_d, store_fin, recall_take;
    logic          pd_fall, recall_pend, dirty;

    pnv_timer #(.CW(CW), .RST_VAL(L_CLEAR)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .cnt_zero(cnt_zero)
    );

    pnv_sense u_sense (
        .clk(clk), .rst_n(rst_n), .vsup_low(vsup_low), .auto_en(auto_en),
        .recall_take(recall_take), .pd_fall(pd_fall), .recall_pend(recall_pend)
    );

    pnv_dirty u_dirty (
        .clk(clk), .rst_n(rst_n), .wr_accept(sram_wr_ok), .store_fin(store_fin), .dirty(dirty)
    );

    // Next-state selection, phase timer loads and completion strobes.
    always_comb begin
        st_d        = st_q;
        ld          = 1'b0;
        ld_val      = '0;
        done_d      = 1'b0;
        store_fin   = 1'b0;
        recall_take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (pd_fall && dirty) begin
                    st_d = ST_PULSE; ld = 1'b1; ld_val = L_PULSE;
                end else if (recall_pend && !vsup_low) begin
                    st_d = ST_CLEAR; ld = 1'b1; ld_val = L_CLEAR; recall_take = 1'b1;
                end else if (sw_store && !vcap_low) begin
                    st_d = ST_ERASE; ld = 1'b1; ld_val = L_ERASE;
                end else if (!busy_line_in) begin
                    if (dirty && !vcap_low) begin
                        st_d = ST_ERASE; ld = 1'b1; ld_val = L_ERASE;
                    end else begin
                        st_d = ST_WAIT;
                    end
                end
            end
            ST_PULSE: if (cnt_zero) begin
                if (!busy_line_in) begin
                    st_d = ST_ERASE; ld = 1'b1; ld_val = L_ERASE;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_ERASE: if (cnt_zero) begin
                st_d = ST_PROG; ld = 1'b1; ld_val = L_PROG;
            end
            ST_PROG: if (cnt_zero) begin
                st_d = ST_WAIT; done_d = 1'b1; store_fin = 1'b1;
            end
            ST_WAIT: if (busy_line_in) st_d = ST_IDLE;
            ST_CLEAR: if (cnt_zero) begin
                st_d = ST_XFER; ld = 1'b1; ld_val = L_XFER;
            end
            ST_XFER: if (cnt_zero) begin
                st_d = ST_IDLE; done_d = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and done pulse registers; reset starts the power-up restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_CLEAR;
            nv_done <= 1'b0;
        end else begin
            st_q    <= st_d;
            nv_done <= done_d;
        end
    end

    assign sram_block    = (st_q != ST_IDLE);
    assign busy_pull_low = (st_q == ST_PULSE) || (st_q == ST_ERASE) || (st_q == ST_PROG);
    assign sram_wr_ok    = sram_wr_req && !sram_block;
    assign sram_rd_ok    = sram_rd_req && !sram_block;
    assign nv_phase      = st_q;

    AST_BLOCKED_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_CLEAR || st_q == ST_XFER) |=> $stable(dirty)); // R2
    AST_PULSE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_PULSE && $past(st_q) != ST_PULSE) |-> $past(dirty)); // R3
    AST_PULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_pull_low) |-> (nv_done || st_q == ST_IDLE)); // R4
    AST_RESTORE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_XFER) |-> ($past(st_q) == ST_CLEAR || $past(st_q) == ST_XFER)); // R5
    AST_SAVE_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WAIT && $past(st_q) == ST_PROG) |-> !dirty); // R6
    AST_LOW_CAP_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_IDLE && vcap_low) |=> st_q != ST_ERASE); // R7
    AST_AUTO_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_IDLE && !auto_en) |=> st_q != ST_PULSE); // R8
    AST_WAIT_FOR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WAIT && !busy_line_in) |=> st_q == ST_WAIT); // R9
endmodule

// File: tb/test_pnv_sequencer.sv
`timescale 1ns/100ps
module test_pnv_sequencer;
    localparam int NV = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsup_low = 1'b0, vcap_low = 1'b0, auto_en = 1'b1, sw_store = 1'b0;
    logic ext_low = 1'b0, ext_high = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
    logic busy_line, pull_low, blk, wr_ok, rd_ok, done;
    logic [2:0] phase;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Wired busy line: an external strong driver can hold it high.
    assign busy_line = ext_high ? 1'b1 : ~(pull_low | ext_low);

    pnv_sequencer #(
        .PULSE_CYC(2), .ERASE_CYC(3), .PROG_CYC(3), .CLEAR_CYC(2), .XFER_CYC(2)
    ) i_pnv_sequencer (
        .clk(clk), .rst_n(rst_n), .vsup_low(vsup_low), .vcap_low(vcap_low),
        .auto_en(auto_en), .sw_store(sw_store), .busy_line_in(busy_line),
        .sram_wr_req(wr_req), .sram_rd_req(rd_req), .busy_pull_low(pull_low),
        .sram_block(blk), .sram_wr_ok(wr_ok), .sram_rd_ok(rd_ok),
        .nv_phase(phase), .nv_done(done)
    );

    // {repeat, inputs vl cl ae sw xl xh wr rd, expected blk drv ph[2:0] dn wok rok}
    localparam logic [19:0] VEC [NV] = '{
        {4'd2, 8'b00100011, 8'b10101000}, {4'd2, 8'b00100011, 8'b10110000},
        {4'd1, 8'b00100001, 8'b00000101}, {4'd2, 8'b10100000, 8'b00000000},
        {4'd1, 8'b00100000, 8'b00000000}, {4'd2, 8'b00100000, 8'b10101000},
        {4'd2, 8'b00100000, 8'b10110000}, {4'd1, 8'b00100010, 8'b00000110},
        {4'd1, 8'b10100000, 8'b00000000}, {4'd2, 8'b10100000, 8'b11001000},
        {4'd3, 8'b10100000, 8'b11010000}, {4'd3, 8'b10100000, 8'b11011000},
        {4'd1, 8'b10100000, 8'b10100100}, {4'd1, 8'b00100000, 8'b00000000},
        {4'd2, 8'b00100000, 8'b10101000}, {4'd2, 8'b00100000, 8'b10110000},
        {4'd1, 8'b00100010, 8'b00000110}, {4'd1, 8'b10100000, 8'b00000000},
        {4'd2, 8'b10100100, 8'b11001000}, {4'd1, 8'b10100000, 8'b00000000},
        {4'd1, 8'b00100000, 8'b00000000}, {4'd2, 8'b00100000, 8'b10101000},
        {4'd2, 8'b00100000, 8'b10110000}, {4'd1, 8'b10000000, 8'b00000100},
        {4'd1, 8'b10000000, 8'b00000000}, {4'd1, 8'b00000000, 8'b00000000},
        {4'd2, 8'b00000000, 8'b10101000}, {4'd2, 8'b00000000, 8'b10110000},
        {4'd1, 8'b01110000, 8'b00000100}, {4'd1, 8'b00110000, 8'b00000000},
        {4'd3, 8'b00100000, 8'b11010000}, {4'd3, 8'b00100000, 8'b11011000},
        {4'd1, 8'b00100000, 8'b10100100}, {4'd1, 8'b00101000, 8'b00000000},
        {4'd1, 8'b00101000, 8'b10100000}, {4'd1, 8'b00100000, 8'b10100000},
        {4'd1, 8'b00100010, 8'b00000010}, {4'd1, 8'b01101000, 8'b00000000},
        {4'd1, 8'b00100000, 8'b10100000}, {4'd1, 8'b00101000, 8'b00000000},
        {4'd3, 8'b00100000, 8'b11010000}, {4'd3, 8'b00100000, 8'b11011000},
        {4'd1, 8'b00100000, 8'b10100100}, {4'd1, 8'b00110000, 8'b00000000},
        {4'd3, 8'b00100000, 8'b11010000}, {4'd3, 8'b00100000, 8'b11011000},
        {4'd1, 8'b00100000, 8'b10100100}, {4'd1, 8'b00100000, 8'b00000000}
    };

    function automatic string req_of(input int i);
        if (i <= 1)  return "R1";
        if (i == 2 || i == 7 || i == 16 || i == 36) return "R2";
        if (i <= 4 || i == 8) return "R3";
        if (i == 9 || (i >= 17 && i <= 19)) return "R4";
        if (i == 10 || i == 11) return "R6";
        if (i == 12 || (i >= 33 && i <= 35) || i == 38) return "R9";
        if (i >= 23 && i <= 27) return "R8";
        if (i == 28 || i == 37) return "R7";
        if (i >= 29) return "R10";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        logic [7:0] got;
        got = {blk, pull_low, phase, done, wr_ok, rd_ok};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got blk/drv/ph/dn/wok/rok=%b expected %b", req, $time, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", 8'b10101000);          // reset holds clear phase, blocked, line released
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            for (int r = 0; r < int'(VEC[i][19:16]); r++) begin
                if (i != 0 || r != 0) @(negedge clk);
                {vsup_low, vcap_low, auto_en, sw_store, ext_low, ext_high, wr_req, rd_req} = VEC[i][15:8];
                #1;
                check(req_of(i), VEC[i][7:0]);
            end
        end
        // Directed: reset in the middle of a save aborts it into the restore (R1)
        @(negedge clk);
        {vsup_low, vcap_low, auto_en, sw_store, ext_low, ext_high, wr_req, rd_req} = 8'b00110001;
        #1; check("R10", 8'b00000001);     // idle, read enabled, save requested
        @(negedge clk);
        sw_store = 1'b0;
        #1; check("R6", 8'b11010000);      // erase with line pulled low
        rst_n = 1'b0;
        @(negedge clk);
        #1; check("R1", 8'b10101000);
        @(negedge clk);
        rst_n = 1'b1;
        #1; check("R1", 8'b10101000);
        repeat (2) @(negedge clk);
        #1; check("R1", 8'b10110000);
        repeat (2) @(negedge clk);
        #1; check("R1", 8'b00000101);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule